// File: doc/BRIEF.md
# Receive Byte Queue with Resident Error Tallies

This block is the receive-side buffer of a serial port. The receiver delivers one byte at a time together with two tags: one tag marks a parity fault and one marks a framing fault. The block holds up to 64 such entries in arrival order and hands back the oldest one on each pop, with its tags.

Alongside the data it keeps two tallies: how many entries now inside the queue carry a parity tag, and how many carry a framing tag. Every push and every pop moves these tallies, so they always describe the queue's present contents rather than a history. Both tallies are packed into a 16-bit read-only status word that software may sample at any time. A single summary flag says whether any resident entry is tagged at all. A synchronous clear input empties the queue in one cycle.

Top module: `rxq_err_fifo`

## Requirements
- R1: Entries leave in the order they were accepted. A pop of a non-empty queue presents that entry's byte and both tags on `pop_data`, `pop_perr` and `pop_ferr` one clock after the pop is sampled, and they hold until the next accepted pop.
- R2: Bits 13 to 8 of `stat_word` equal, modulo 64, the number of resident entries whose parity tag is set.
- R3: Bits 5 to 0 of `stat_word` equal, modulo 64, the number of resident entries whose framing tag is set.
- R4: Bits 15, 14, 7 and 6 of `stat_word` are always 0.
- R5: When a push and a pop are accepted in the same cycle, each tally adds the incoming tag and subtracts the outgoing tag, so it moves by at most one, and the occupancy is unchanged.
- R6: With all 64 resident entries carrying the same tag, that tally field reads 0 while `err_any` stays 1.
- R7: `err_any` is 1 exactly when at least one resident entry has either tag set, and is 0 whenever the queue is empty.
- R8: A push while the queue holds 64 entries and no pop is accepted is discarded: occupancy, tallies and queue contents are unchanged, and `overrun` becomes 1 and stays 1 until `clr` or reset.
- R9: A pop of an empty queue changes nothing: `pop_data`, the output tags, the tallies and the occupancy keep their values.
- R10: `clr` high for one clock empties the queue and zeroes both tallies, `err_any` and `overrun` after that clock edge; push and pop in the same cycle are ignored.
- R11: After reset, `level` is 0, `empty` is 1, `full` is 0, `stat_word` is 0, `err_any` and `overrun` are 0, and `pop_data` and its tags are 0.
- R12: `level` gives the number of resident entries (0 to 64), `full` is 1 exactly at 64 and `empty` exactly at 0; all update one clock after the accepted push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous queue clear |
| push | input | 1 | Offer one byte to the queue |
| push_data | input | 8 | Byte offered |
| push_perr | input | 1 | Parity tag of the offered byte |
| push_ferr | input | 1 | Framing tag of the offered byte |
| pop | input | 1 | Remove the oldest entry |
| pop_data | output | 8 | Byte of the last popped entry |
| pop_perr | output | 1 | Parity tag of the last popped entry |
| pop_ferr | output | 1 | Framing tag of the last popped entry |
| level | output | 7 | Number of resident entries |
| full | output | 1 | Queue holds 64 entries |
| empty | output | 1 | Queue holds no entry |
| overrun | output | 1 | Sticky: a push was discarded |
| err_any | output | 1 | Some resident entry is tagged |
| stat_word | output | 16 | Parity tally in 13:8, framing tally in 5:0 |

## Verification
The tallies are driven with streams whose tags alternate, cluster or appear on every byte, so a counter that only counts up, or swaps the two tag kinds, diverges from a count taken over the model queue. Same-cycle push and pop with differing tags separates a correct add-and-subtract from one that lets either side win. Filling all 64 slots with parity faults shows the modulo-64 wrap against a still-set summary flag, and pushing once more at full, popping at empty and clearing with a push pending show that dropped or ignored operations leave the data path and the tallies alone.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned STAT_W  = 16;
  localparam int unsigned FIELD_W = 6;
  localparam int unsigned PAR_LSB = 8;
  localparam int unsigned FRM_LSB = 0;

  localparam int unsigned TAG_N   = 2;
  localparam int unsigned TAG_PAR = 0;
  localparam int unsigned TAG_FRM = 1;

  typedef logic [TAG_N-1:0] rxq_tag_t;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic [FIELD_W-1:0] par_field,
    input logic [FIELD_W-1:0] frm_field
  );
    logic [STAT_W-1:0] w;
    w = '0;
    w[PAR_LSB +: FIELD_W] = par_field;
    w[FRM_LSB +: FIELD_W] = frm_field;
    return w;
  endfunction

endpackage

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          overrun
);

  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] lvl_q;
  logic          ovr_q;

  assign full  = (lvl_q == LVL_MAX);
  assign empty = (lvl_q == '0);

  // a pop is taken only from a non-empty queue; a push at full rides on a same-cycle pop
  assign rd_en = pop && !empty && !clr;
  assign wr_en = push && (!full || rd_en) && !clr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (wr_en) wr_q <= bump(wr_q);
      if (rd_en) rd_q <= bump(rd_q);
      lvl_q <= lvl_q + LW'(wr_en) - LW'(rd_en);
      if (push && !wr_en) ovr_q <= 1'b1;
    end
  end

  assign wr_addr = wr_q;
  assign rd_addr = rd_q;
  assign level   = lvl_q;
  assign overrun = ovr_q;

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R12
  level_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_MAX);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(overrun) && !$past(clr)) |-> overrun);

  // R9
  empty_pop_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !clr) |=> empty);

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned TW = rxq_pkg::TAG_N,
  localparam int unsigned EW = DATA_W + TW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [EW-1:0] wr_entry,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [EW-1:0] rd_entry,
  output logic [TW-1:0] head_tag
);

  // data and tags in one wide word: simple dual-port RAM with a registered read
  logic [EW-1:0] ram [DEPTH];
  logic [EW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_addr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= ram[rd_addr];
  end

  assign rd_entry = rd_q;

  // small tag shadow read asynchronously so the tallies learn the outgoing tag in the pop cycle
  logic [TW-1:0] tag_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_addr] <= wr_entry[TW-1:0];
  end

  assign head_tag = tag_mem[rd_addr];

endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [LW-1:0] cnt
);

  localparam logic [LW-1:0] CNT_MAX = LW'(DEPTH);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else            cnt_q <= cnt_q + LW'(inc) - LW'(dec);
  end

  assign cnt = cnt_q;

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R2
  tally_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);

  // R5
  tally_single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(clr)) |->
      (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rxq_err_fifo.sv
module rxq_err_fifo #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_perr,
  input  logic              push_ferr,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_perr,
  output logic              pop_ferr,
  output logic [LW-1:0]     level,
  output logic              full,
  output logic              empty,
  output logic              overrun,
  output logic              err_any,
  output logic [15:0]       stat_word
);

  import rxq_pkg::*;

  localparam int unsigned EW = DATA_W + TAG_N;

  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  rxq_tag_t      in_tag, head_tag;
  logic [EW-1:0] rd_entry;

  assign in_tag[TAG_PAR] = push_perr;
  assign in_tag[TAG_FRM] = push_ferr;

  rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .push    (push),
    .pop     (pop),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .level   (level),
    .full    (full),
    .empty   (empty),
    .overrun (overrun)
  );

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_entry ({push_data, in_tag}),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_entry (rd_entry),
    .head_tag (head_tag)
  );

  assign pop_data = rd_entry[EW-1:TAG_N];
  assign pop_perr = rd_entry[TAG_PAR];
  assign pop_ferr = rd_entry[TAG_FRM];

  // one resident-entry tally per tag kind, kept one bit wider than the status field
  logic [LW-1:0] tally [TAG_N];

  for (genvar k = 0; k < TAG_N; k++) begin : g_tally
    rxq_errcnt #(.DEPTH(DEPTH)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (clr),
      .inc (wr_en && in_tag[k]),
      .dec (rd_en && head_tag[k]),
      .cnt (tally[k])
    );
  end

  // the wide tally sees the full-queue case that the 6-bit field wraps to zero
  assign err_any = (tally[TAG_PAR] != '0) || (tally[TAG_FRM] != '0);

  logic [LW+FIELD_W-1:0] par_ext, frm_ext;
  assign par_ext = {{FIELD_W{1'b0}}, tally[TAG_PAR]};
  assign frm_ext = {{FIELD_W{1'b0}}, tally[TAG_FRM]};

  assign stat_word = pack_status(par_ext[FIELD_W-1:0], frm_ext[FIELD_W-1:0]);

  // R2
  par_within_level_chk: assert property (@(posedge clk) disable iff (rst)
    tally[TAG_PAR] <= level);

  // R3
  frm_within_level_chk: assert property (@(posedge clk) disable iff (rst)
    tally[TAG_FRM] <= level);

  // R7
  empty_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> !err_any);

  // R10
  clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (empty && !err_any && !overrun));

endmodule

// File: tb/rxq_err_fifo_bench.sv
`timescale 1ns/1ps
module rxq_err_fifo_bench;

  logic       clk = 1'b0;
  logic       rst, clr, push, push_perr, push_ferr, pop;
  logic [7:0] push_data;
  logic [7:0] pop_data;
  logic       pop_perr, pop_ferr, full, empty, overrun, err_any;
  logic [6:0] level;
  logic [15:0] stat_word;

  always #2 clk = ~clk;

  rxq_err_fifo u_rxq_err_fifo (
    .clk(clk), .rst(rst), .clr(clr), .push(push), .push_data(push_data),
    .push_perr(push_perr), .push_ferr(push_ferr), .pop(pop),
    .pop_data(pop_data), .pop_perr(pop_perr), .pop_ferr(pop_ferr),
    .level(level), .full(full), .empty(empty), .overrun(overrun),
    .err_any(err_any), .stat_word(stat_word)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model: entry = {data, ferr, perr}
  logic [9:0] q[$];
  logic [9:0] last_pop = '0;
  bit         m_ovr = 0;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    int np = 0;
    int nf = 0;
    foreach (q[i]) begin
      np += int'(q[i][0]);
      nf += int'(q[i][1]);
    end
    chk(req, "level", 16'(level), 16'(q.size()));
    chk(req, "full/empty", {14'd0, full, empty}, {14'd0, q.size() == 64, q.size() == 0});
    chk(req, "stat_word", stat_word, {2'b00, 6'(np), 2'b00, 6'(nf)});
    chk(req, "err_any", 16'(err_any), 16'((np + nf) != 0));
    chk(req, "overrun", 16'(overrun), 16'(m_ovr));
    chk(req, "pop out", {6'd0, pop_data, pop_ferr, pop_perr}, {6'd0, last_pop});
  endtask

  task automatic cyc(input logic ps, input logic [7:0] d, input logic pe, input logic fe,
                     input logic pp, input logic cl, input string req);
    bit pop_ok, push_ok;
    push = ps; push_data = d; push_perr = pe; push_ferr = fe; pop = pp; clr = cl;
    @(negedge clk);
    if (cl) begin
      q.delete();
      m_ovr = 0;
    end else begin
      pop_ok  = pp && (q.size() > 0);
      push_ok = ps && ((q.size() < 64) || pop_ok);
      if (pop_ok) last_pop = q.pop_front();
      if (push_ok) q.push_back({d, fe, pe});
      if (ps && !push_ok) m_ovr = 1;
    end
    push = 0; pop = 0; clr = 0; push_perr = 0; push_ferr = 0;
    compare(req);
  endtask

  task automatic t_reset;
    chk("R11", "level", 16'(level), 16'd0);
    chk("R11", "empty/full", {14'd0, empty, full}, 16'b10);
    chk("R11", "stat_word", stat_word, 16'd0);
    chk("R11", "err/ovr", {14'd0, err_any, overrun}, 16'd0);
    chk("R11", "pop out", {6'd0, pop_data, pop_ferr, pop_perr}, 16'd0);
  endtask

  task automatic t_order;
    cyc(1, 8'h11, 1, 0, 0, 0, "R2");
    cyc(1, 8'h22, 0, 1, 0, 0, "R3");
    cyc(1, 8'h33, 1, 1, 0, 0, "R2");
    cyc(1, 8'h44, 0, 0, 0, 0, "R12");
    chk("R4", "reserved", {12'd0, stat_word[15:14], stat_word[7:6]}, 16'd0);
    for (int i = 0; i < 4; i++) cyc(0, 8'h00, 0, 0, 1, 0, "R1");
    chk("R1", "last byte", 16'(pop_data), 16'h44);
  endtask

  task automatic t_simul;
    cyc(1, 8'hA1, 1, 0, 0, 0, "R5");
    cyc(1, 8'hA2, 0, 1, 1, 0, "R5");   // parity leaves, framing enters
    cyc(1, 8'hA3, 0, 1, 1, 0, "R5");   // framing leaves and enters
    cyc(1, 8'hA4, 1, 1, 1, 0, "R5");
    cyc(0, 8'h00, 0, 0, 1, 0, "R7");
    chk("R7", "err_any empty", 16'(err_any), 16'd0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 64; i++) cyc(1, 8'(i + 8'h40), 1, i[0], 0, 0, "R12");
    chk("R6", "parity field", 16'(stat_word[13:8]), 16'd0);
    chk("R6", "err_any", 16'(err_any), 16'd1);
    chk("R3", "framing field", 16'(stat_word[5:0]), 16'd32);
    cyc(1, 8'hEE, 0, 0, 0, 0, "R8");
    chk("R8", "overrun", 16'(overrun), 16'd1);
    cyc(1, 8'hC0, 0, 1, 1, 0, "R5");   // push at full accepted with pop
    for (int i = 0; i < 64; i++) cyc(0, 8'h00, 0, 0, 1, 0, "R1");
    chk("R1", "final byte", 16'(pop_data), 16'hC0);
  endtask

  task automatic t_empty_pop;
    cyc(0, 8'h00, 0, 0, 1, 0, "R9");
    cyc(0, 8'h00, 0, 0, 1, 0, "R9");
    chk("R9", "pop data held", 16'(pop_data), 16'hC0);
    chk("R8", "overrun sticky", 16'(overrun), 16'd1);
  endtask

  task automatic t_clear;
    cyc(1, 8'h51, 1, 0, 0, 0, "R10");
    cyc(1, 8'h52, 0, 1, 0, 0, "R10");
    cyc(1, 8'h53, 1, 1, 1, 1, "R10");
    chk("R10", "after clr", {stat_word[13:0], err_any, overrun}, 16'd0);
    chk("R10", "level", 16'(level), 16'd0);
    cyc(1, 8'h61, 0, 1, 0, 0, "R7");
    cyc(0, 8'h00, 0, 0, 1, 0, "R1");
  endtask

  initial begin
    rst = 1; clr = 0; push = 0; pop = 0; push_data = 0; push_perr = 0; push_ferr = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_order();
    t_simul();
    t_full();
    t_empty_pop();
    t_clear();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule